// File: doc/BRIEF.md
# Buffered SPI Command Engine

This block is a single-bit SPI master that runs one serial-flash style command per trigger. Software loads a shared byte buffer with everything to be sent (opcode, address bytes, dummy bytes, write data), writes a send count and a receive count, then sets enable and trigger together in the control register. The engine pulls chip select low, shifts the send bytes out, keeps clocking to collect the requested number of response bytes, and writes each response byte back into the same buffer directly after the last sent byte. It then releases chip select.

Start uses two phases. A ready flag reports that the trigger was taken. A busy flag stays high until the last response byte is stored. Software closes the operation by clearing enable and trigger. A soft-reset bit forces the engine back to idle at any time, and a 4-bit state field reads zero once it is there. Lengths that do not fit the buffer, and requests for a multi-bit I/O mode, are refused.

All traffic goes through a plain register port: one access per cycle, and read data returned on the next cycle with a one-cycle valid strobe. There is no back-pressure. The serial side is SPI mode 0, MSB first.

Top module: `spi_cmd_engine`

## Requirements
- R1: Buffer words sit at register word addresses 0x40 upward, 32 bits each. Byte n of the buffer is bits [8*(n%4)+7 : 8*(n%4)] of word 0x40+n/4. A read of a word address past the buffer returns zero.
- R2: Buffer bytes 0 to send count minus 1 go out on MOSI in order, MSB first. Each bit is stable at the rising SCLK edge (mode 0, SCLK idles low).
- R3: Received bytes are stored at byte positions starting at the send count and running contiguously, so they may start mid-word. Bytes outside the received range keep their values.
- R4: Chip select stays low without a break from the first sent bit to the last received bit. A transfer gives exactly 8*(send+receive) SCLK pulses, and SCLK is low whenever chip select is high.
- R5: With enable set, setting trigger sets ready (control bit 1) and busy (control bit 0). Busy clears after the last byte and ready stays set. Writing control with enable cleared returns ready to 0. No second transfer starts while ready is still set.
- R6: A trigger written while enable (control bit 3) is clear has no effect.
- R7: A trigger with send and receive counts both zero sets ready, never raises busy, and never asserts chip select.
- R8: If send plus receive exceeds the buffer size (160), the trigger is ignored and error (control bit 5) is set. Error blocks further triggers until a control write raises enable from 0 to 1. A total of exactly 160 is accepted.
- R9: With the I/O mode select bit (control bit 4) set, a trigger is ignored.
- R10: Writing 1 to soft reset (word 4, bit 0) aborts a transfer. Chip select goes high, busy and ready clear, and the state field reads 0.
- R11: The SCLK period is CLK_DIV system clocks, high for CLK_DIV/2 of them.
- R12: The register map is: control at word 0 (trigger bit 2 and enable bit 3 read back), send count at word 1, receive count at word 2, 4-bit state field at word 3 bits [3:0]. Everything reads zero after reset, and the state field is nonzero while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 7 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the access |
| reg_rvalid | output | 1 | Read data valid strobe |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The bench builds the engine with CLK_DIV=2 and the default 160-byte buffer. The smallest divider keeps a full-buffer command near two and a half thousand cycles, so the 160-byte acceptance boundary and the 161-byte refusal can both be run as real transfers. A behavioural flash model returns a known byte sequence. This exposes the mid-word receive placement, the one-cycle SCLK half period and the abort of a long receive.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  // register word addresses
  localparam logic [6:0] RA_CTRL  = 7'h00;
  localparam logic [6:0] RA_TXCNT = 7'h01;
  localparam logic [6:0] RA_RXCNT = 7'h02;
  localparam logic [6:0] RA_STATE = 7'h03;
  localparam logic [6:0] RA_SRST  = 7'h04;

  // control bit positions
  localparam int CB_BUSY  = 0;
  localparam int CB_READY = 1;
  localparam int CB_TRIG  = 2;
  localparam int CB_EN    = 3;
  localparam int CB_MODE  = 4;
  localparam int CB_ERR   = 5;

  typedef enum logic [3:0] {
    ST_IDLE  = 4'd0,
    ST_LOAD  = 4'd1,
    ST_SHIFT = 4'd2,
    ST_CLOSE = 4'd3
  } eng_state_e;
endpackage

// File: rtl/spi_cmd_buffer.sv
module spi_cmd_buffer #(
  parameter int WORDS = 40,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             sw_we,
  input  logic [IDX_W-1:0] sw_idx,
  input  logic [31:0]      sw_wdata,
  output logic [31:0]      sw_rdata,
  input  logic [IDX_W+1:0] eng_pos,
  input  logic             eng_we,
  input  logic [7:0]       eng_wbyte,
  output logic [7:0]       eng_rbyte
);
  logic [31:0]      words [WORDS];
  logic [IDX_W-1:0] eng_idx;
  logic [31:0]      eng_word;

  assign eng_idx = eng_pos[IDX_W+1:2];

  // one storage word per slot; engine byte write wins over software lane
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [31:0] word_q;
    always_ff @(posedge clk) begin
      for (int l = 0; l < 4; l++) begin
        if (eng_we && eng_idx == IDX_W'(w) && eng_pos[1:0] == 2'(l))
          word_q[8*l +: 8] <= eng_wbyte;
        else if (sw_we && sw_idx == IDX_W'(w))
          word_q[8*l +: 8] <= sw_wdata[8*l +: 8];
      end
    end
    assign words[w] = word_q;
  end

  always_comb begin
    sw_rdata = '0;
    if (int'(sw_idx) < WORDS) sw_rdata = words[sw_idx];
    eng_word = '0;
    if (int'(eng_idx) < WORDS) eng_word = words[eng_idx];
    eng_rbyte = eng_word[8*eng_pos[1:0] +: 8];
  end
endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter #(
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       abort,
  input  logic       start,
  input  logic       send,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx_byte
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] hcnt_q;
  logic [7:0]    sh_q;
  logic [2:0]    bit_q;
  logic          smp_q, sclk_q, act_q, done_q, snd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q <= '0; sh_q <= '0; bit_q <= '0; smp_q <= 1'b0;
      sclk_q <= 1'b0; act_q <= 1'b0; done_q <= 1'b0; snd_q <= 1'b0;
    end else if (abort) begin
      hcnt_q <= '0; bit_q <= '0; sclk_q <= 1'b0; act_q <= 1'b0;
      done_q <= 1'b0; snd_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        sh_q   <= tx_byte;
        bit_q  <= '0;
        hcnt_q <= '0;
        sclk_q <= 1'b0;
        act_q  <= 1'b1;
        snd_q  <= send;
      end else if (act_q) begin
        if (hcnt_q == CW'(HALF - 1)) begin
          hcnt_q <= '0;
          if (!sclk_q) begin
            sclk_q <= 1'b1;       // rising edge: sample input
            smp_q  <= miso;
          end else begin
            sclk_q <= 1'b0;       // falling edge: advance
            sh_q   <= {sh_q[6:0], smp_q};
            bit_q  <= bit_q + 3'd1;
            if (bit_q == 3'd7) begin
              act_q  <= 1'b0;
              done_q <= 1'b1;
            end
          end
        end else begin
          hcnt_q <= hcnt_q + CW'(1);
        end
      end
    end
  end

  assign sclk    = sclk_q;
  assign mosi    = act_q & snd_q & sh_q[7];
  assign done    = done_q;
  assign rx_byte = sh_q;
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int BUF_BYTES = 160,
  parameter int CLK_DIV   = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_sel,
  input  logic        reg_we,
  input  logic [6:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        reg_rvalid,
  output logic        spi_sclk,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam int WORDS = (BUF_BYTES + 3) / 4;
  localparam int POS_W = $clog2(BUF_BYTES + 1);
  localparam int SUM_W = POS_W + 1;
  localparam int IDX_W = POS_W - 2;

  // software-owned registers
  logic             trig_q, en_q, mode_q, srst_q;
  logic [POS_W-1:0] txcnt_q, rxcnt_q;
  // engine-owned registers
  eng_state_e       state_q;
  logic             ready_q, err_q, cs_n_q;
  logic [POS_W-1:0] pos_q, lat_tx_q, lat_end_q;

  logic             wr, rd, ctrl_wr, en_rise, buf_hit;
  logic [SUM_W-1:0] total;
  logic             busy, try_go, sh_start, sh_send, sh_done, rx_we;
  logic [7:0]       sh_rx, buf_rbyte;
  logic [31:0]      buf_rdata;

  assign wr      = reg_sel & reg_we;
  assign rd      = reg_sel & ~reg_we;
  assign ctrl_wr = wr && reg_addr == RA_CTRL;
  assign en_rise = ctrl_wr && reg_wdata[CB_EN] && !en_q;
  assign buf_hit = reg_addr[6] && (int'(reg_addr[5:0]) < WORDS);
  assign total   = SUM_W'(txcnt_q) + SUM_W'(rxcnt_q);
  assign busy    = state_q != ST_IDLE;
  assign try_go  = trig_q & en_q & ~mode_q & ~ready_q & ~err_q & ~srst_q;

  // register writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= 1'b0; en_q <= 1'b0; mode_q <= 1'b0; srst_q <= 1'b0;
      txcnt_q <= '0; rxcnt_q <= '0;
    end else if (wr) begin
      case (reg_addr)
        RA_CTRL: begin
          trig_q <= reg_wdata[CB_TRIG];
          en_q   <= reg_wdata[CB_EN];
          mode_q <= reg_wdata[CB_MODE];
        end
        RA_TXCNT: txcnt_q <= reg_wdata[POS_W-1:0];
        RA_RXCNT: rxcnt_q <= reg_wdata[POS_W-1:0];
        RA_SRST:  srst_q  <= reg_wdata[0];
        default: ;
      endcase
    end
  end

  // register reads, one cycle latency
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= rd;
      if (rd) begin
        reg_rdata <= '0;
        if (buf_hit) reg_rdata <= buf_rdata;
        else begin
          case (reg_addr)
            RA_CTRL:  reg_rdata <= 32'({err_q, mode_q, en_q, trig_q, ready_q, busy});
            RA_TXCNT: reg_rdata <= 32'(txcnt_q);
            RA_RXCNT: reg_rdata <= 32'(rxcnt_q);
            RA_STATE: reg_rdata <= 32'(state_q);
            RA_SRST:  reg_rdata <= 32'(srst_q);
            default:  reg_rdata <= '0;
          endcase
        end
      end
    end
  end

  // command sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; ready_q <= 1'b0; err_q <= 1'b0; cs_n_q <= 1'b1;
      pos_q <= '0; lat_tx_q <= '0; lat_end_q <= '0;
    end else if (srst_q) begin
      state_q <= ST_IDLE;
      ready_q <= 1'b0;
      cs_n_q  <= 1'b1;
      if (en_rise) err_q <= 1'b0;
    end else begin
      if (en_rise) err_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (!en_q) ready_q <= 1'b0;
          if (try_go) begin
            if (total > SUM_W'(BUF_BYTES)) begin
              err_q <= 1'b1;
            end else begin
              ready_q   <= 1'b1;
              lat_tx_q  <= txcnt_q;
              lat_end_q <= POS_W'(total);
              pos_q     <= '0;
              if (total != '0) begin
                state_q <= ST_LOAD;
                cs_n_q  <= 1'b0;
              end
            end
          end
        end
        ST_LOAD:  state_q <= (pos_q == lat_end_q) ? ST_CLOSE : ST_SHIFT;
        ST_SHIFT: begin
          if (sh_done) begin
            pos_q   <= pos_q + POS_W'(1);
            state_q <= ST_LOAD;
          end
        end
        ST_CLOSE: begin
          cs_n_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sh_start = (state_q == ST_LOAD) && (pos_q != lat_end_q);
  assign sh_send  = pos_q < lat_tx_q;
  assign rx_we    = (state_q == ST_SHIFT) && sh_done && !sh_send && !srst_q;

  spi_cmd_buffer #(.WORDS(WORDS), .IDX_W(IDX_W)) u_buf (
    .clk      (clk),
    .sw_we    (wr && buf_hit),
    .sw_idx   (IDX_W'(reg_addr[5:0])),
    .sw_wdata (reg_wdata),
    .sw_rdata (buf_rdata),
    .eng_pos  (pos_q),
    .eng_we   (rx_we),
    .eng_wbyte(sh_rx),
    .eng_rbyte(buf_rbyte)
  );

  spi_cmd_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .abort  (srst_q),
    .start  (sh_start),
    .send   (sh_send),
    .tx_byte(buf_rbyte),
    .miso   (spi_miso),
    .sclk   (spi_sclk),
    .mosi   (spi_mosi),
    .done   (sh_done),
    .rx_byte(sh_rx)
  );

  assign spi_cs_n = cs_n_q;
endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       sclk,
  input logic       ready,
  input logic       err,
  input logic       en,
  input logic       srst,
  input logic [3:0] state
);
  logic busy;
  assign busy = state != 4'd0;

  assert_sclk_parked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  assert_cs_needs_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);
  assert_busy_needs_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ready);
  assert_ready_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && en && !srst) |=> ready);
  assert_ready_needs_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(en));
  assert_err_excludes_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(err && ready));
  assert_srst_idles_R10: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (state == 4'd0 && cs_n));
endmodule

bind spi_cmd_engine spi_cmd_engine_chk u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .cs_n (spi_cs_n),
  .sclk (spi_sclk),
  .ready(ready_q),
  .err  (err_q),
  .en   (en_q),
  .srst (srst_q),
  .state(state_q)
);

// File: tb/test_spi_cmd_engine.sv
module test_spi_cmd_engine;
  localparam int BUF_BYTES = 160;
  localparam int CLK_DIV   = 2;
  localparam int WORDS     = BUF_BYTES / 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0, reg_we = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic        spi_sclk, spi_cs_n, spi_mosi;
  logic        spi_miso = 1'b0;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;
  int cyc = 0;
  int cs_falls = 0, sclk_rises = 0, sbit = 0, rbit = 0;
  int rise_cyc [2];
  logic [7:0] cap [256];
  logic [7:0] img [BUF_BYTES];

  spi_cmd_engine #(.BUF_BYTES(BUF_BYTES), .CLK_DIV(CLK_DIV)) i_spi_cmd_engine (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  always #10 clk = ~clk;

  function automatic logic [7:0] resp(input int k);
    return 8'((k * 29 + 8'h5A) ^ 8'hC3);
  endfunction
  function automatic logic [7:0] pat(input int n);
    return 8'(n * 13 + 7);
  endfunction

  // cycle counter and flash model
  initial forever begin @(posedge clk); cyc++; end
  initial forever begin
    @(negedge spi_cs_n);
    cs_falls++; sbit = 0; rbit = 0;
    spi_miso = resp(0)[7];
  end
  initial forever begin
    @(negedge spi_sclk);
    if (!spi_cs_n) begin
      sbit++;
      spi_miso = resp(sbit / 8)[7 - sbit % 8];
    end
  end
  initial forever begin
    @(posedge spi_sclk);
    if (rbit < 2) rise_cyc[rbit] = cyc;
    if (rbit < 2048) cap[rbit / 8][7 - rbit % 8] = spi_mosi;
    rbit++; sclk_rises++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_we = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_sel = 1'b0;
    d = reg_rdata;
  endtask

  // fill buffer: bytes below tx get pattern, the rest a sentinel
  task automatic fill(input int tx);
    for (int w = 0; w < WORDS; w++) begin
      logic [31:0] v;
      for (int l = 0; l < 4; l++) v[8*l +: 8] = (4*w + l < tx) ? pat(4*w + l) : 8'hEE;
      wr(7'h40 + 7'(w), v);
    end
  endtask

  task automatic grab;
    for (int w = 0; w < WORDS; w++) begin
      logic [31:0] v;
      rd(7'h40 + 7'(w), v);
      for (int l = 0; l < 4; l++) img[4*w + l] = v[8*l +: 8];
    end
  endtask

  task automatic wait_idle;
    logic [31:0] v;
    for (int i = 0; i < 20000; i++) begin
      rd(7'h00, v);
      if (!v[0]) break;
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(7'h00, v); check(v == 0, "R12 ctrl after reset", v, 0);
    rd(7'h03, v); check(v == 0, "R12 state after reset", v, 0);
    check(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R4 idle pins", {spi_cs_n, spi_sclk}, 2);
  endtask

  task automatic t_buffer;
    logic [31:0] v;
    wr(7'h40 + 7'd3, 32'hA1B2C3D4);
    rd(7'h40 + 7'd3, v); check(v == 32'hA1B2C3D4, "R1 word roundtrip", v, 32'hA1B2C3D4);
    rd(7'h40 + 7'(WORDS), v); check(v == 0, "R1 past end reads zero", v, 0);
  endtask

  task automatic t_xfer(input int tx, input int rx);
    logic [31:0] v;
    int c0;
    fill(tx);
    wr(7'h01, tx); wr(7'h02, rx);
    rd(7'h01, v); check(v == tx, "R12 send count readback", v, tx);
    c0 = cs_falls; sclk_rises = 0;
    wr(7'h00, 32'h0C);
    rd(7'h00, v);
    check(v[1] && v[0], "R5 ready and busy after trigger", v, 3);
    rd(7'h03, v); check(v != 0, "R12 state nonzero while busy", v, 1);
    wait_idle();
    rd(7'h00, v); check(v == 32'h0E, "R5 ready held, busy clear", v, 32'h0E);
    check(cs_falls == c0 + 1, "R4 one chip select window", cs_falls - c0, 1);
    check(sclk_rises == 8 * (tx + rx), "R4 clock count", sclk_rises, 8 * (tx + rx));
    check(rise_cyc[1] - rise_cyc[0] == CLK_DIV, "R11 sclk period", rise_cyc[1] - rise_cyc[0], CLK_DIV);
    begin
      int bad = 0;
      for (int i = 0; i < tx; i++) if (cap[i] !== pat(i)) bad++;
      check(bad == 0, "R2 sent bytes", bad, 0);
    end
    grab();
    begin
      int bad = 0, keep = 0;
      for (int j = 0; j < rx; j++) if (img[tx + j] !== resp(tx + j)) bad++;
      for (int n = 0; n < BUF_BYTES; n++) begin
        if (n < tx && img[n] !== pat(n)) keep++;
        if (n >= tx + rx && img[n] !== 8'hEE) keep++;
      end
      check(bad == 0, "R3 received bytes placed", bad, 0);
      check(keep == 0, "R3 other bytes untouched", keep, 0);
    end
    repeat (30) @(negedge clk);
    check(cs_falls == c0 + 1, "R5 no restart while ready", cs_falls - c0, 1);
    wr(7'h00, 32'h0);
    rd(7'h00, v); check(v == 0, "R5 ready cleared by disable", v, 0);
  endtask

  task automatic t_no_enable;
    logic [31:0] v;
    int c0 = cs_falls;
    wr(7'h01, 2); wr(7'h02, 1);
    wr(7'h00, 32'h04);
    repeat (20) @(negedge clk);
    rd(7'h00, v); check(v == 32'h04, "R6 trigger alone ignored", v, 32'h04);
    check(cs_falls == c0, "R6 no chip select", cs_falls - c0, 0);
    wr(7'h00, 0);
  endtask

  task automatic t_zero;
    logic [31:0] v;
    int c0 = cs_falls;
    wr(7'h01, 0); wr(7'h02, 0);
    wr(7'h00, 32'h0C);
    rd(7'h00, v); check(v == 32'h0E, "R7 empty command ready no busy", v, 32'h0E);
    repeat (10) @(negedge clk);
    check(cs_falls == c0, "R7 no chip select", cs_falls - c0, 0);
    wr(7'h00, 0);
  endtask

  task automatic t_overflow;
    logic [31:0] v;
    int c0 = cs_falls;
    wr(7'h01, 100); wr(7'h02, 61);
    wr(7'h00, 32'h0C);
    repeat (5) @(negedge clk);
    rd(7'h00, v); check(v == 32'h2C, "R8 error set, not ready", v, 32'h2C);
    wr(7'h02, 60);
    repeat (5) @(negedge clk);
    rd(7'h00, v); check(v == 32'h2C, "R8 error blocks until enable", v, 32'h2C);
    check(cs_falls == c0, "R8 no chip select", cs_falls - c0, 0);
    wr(7'h00, 0);
    wr(7'h01, 1); wr(7'h02, 1);
    wr(7'h00, 32'h0C);
    rd(7'h00, v); check(v[5] == 1'b0 && v[1], "R8 error cleared on enable", v, 32'h0F);
    wait_idle();
    wr(7'h00, 0);
  endtask

  task automatic t_mode;
    logic [31:0] v;
    int c0 = cs_falls;
    wr(7'h01, 1); wr(7'h02, 1);
    wr(7'h00, 32'h1C);
    repeat (10) @(negedge clk);
    rd(7'h00, v); check(v == 32'h1C, "R9 mode select refuses", v, 32'h1C);
    check(cs_falls == c0, "R9 no chip select", cs_falls - c0, 0);
    wr(7'h00, 0);
  endtask

  task automatic t_srst;
    logic [31:0] v;
    wr(7'h01, 0); wr(7'h02, 100);
    wr(7'h00, 32'h0C);
    repeat (60) @(negedge clk);
    check(spi_cs_n == 1'b0, "R10 transfer running", spi_cs_n, 0);
    wr(7'h04, 1);
    repeat (2) @(negedge clk);
    check(spi_cs_n == 1'b1, "R10 chip select released", spi_cs_n, 1);
    rd(7'h00, v); check(v[1:0] == 2'b00, "R10 busy and ready clear", v, 32'h0C);
    rd(7'h03, v); check(v == 0, "R10 state field zero", v, 0);
    wr(7'h04, 0);
    wr(7'h00, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_buffer();
    t_xfer(4, 3);
    t_xfer(5, 6);
    t_xfer(1, 0);
    t_xfer(0, 2);
    t_xfer(2, 158);
    t_no_enable();
    t_zero();
    t_overflow();
    t_mode();
    t_srst();
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule